// File: doc/BRIEF.md
# Bank Translation Register File

This block is the register file behind a paged memory manager on an 8-bit CPU I/O bus. It stores one translation entry for each logical 4 KB bank. The entries are grouped into segments of sixteen. One register selects the active segment, another holds a window offset, and a control register carries three enable bits.

The CPU reaches every register through a small window of byte offsets. Reads are combinational. Writes take effect on the clock edge on which the write strobe is sampled.

A separate lookup port lets the translation datapath fetch the entry for any bank of the active segment without using the bus. When a write changes the manager's enable state, the block raises a one-cycle request so that the CPU clock rate can be re-evaluated.

The `EXTENDED` parameter picks between two configurations:

- **Base:** a 2-bit segment select and 6-bit entries.
- **Extended:** a 3-bit segment select and full 8-bit entries.

The defaults give the base configuration.

Top module: `mmr_bank_regs`

## Requirements
- R1: While reset is low, and after it is released, the following are all zero: the three enable flags, the window offset, the segment select, the re-evaluation pulse and every table entry.
- R2: A write to any offset 0x80..0x8F stores its data into the entry for bank (offset - 0x80) of the current segment. A read of the same offset returns that entry. In the base configuration only data bits 5:0 are kept and bits 7:6 read as 0; in the extended configuration all 8 bits are kept.
- R3: A write to offset 0x90 loads the segment select from data bits 1:0 in the base configuration, or from bits 2:0 in the extended one. Higher data bits are ignored. The table index is bank + 16 × segment, so each segment holds its own sixteen entries.
- R4: A write to offset 0x92 loads the 8-bit window offset. The value drives the `win_offset` output and is returned by a read of 0x92.
- R5: A write to offset 0x93 loads three flags: boot-RAM from bit 0, window enable from bit 6 and manager enable from bit 7. The other data bits have no effect.
- R6: A read of offset 0x93 returns 0x3E with bit 0 set to boot-RAM, bit 6 to window enable and bit 7 to manager enable.
- R7: `clk_reeval` is high for exactly the cycle after a write edge that changed the manager enable flag. It stays low after a write that leaves that flag unchanged, and after any other write.
- R8: `lookup_entry` returns, combinationally, the entry for bank `lookup_bank` in the current segment, zero-extended to 8 bits.
- R9: A read of any offset other than 0x80..0x8F, 0x92 and 0x93 (0x90 included) returns 0xFF. A write to an offset outside 0x80..0x8F, 0x90, 0x92 and 0x93 changes no register.
- R10: A value written is visible on `bus_rdata`, `lookup_entry` and the flag outputs in the cycle that follows its write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| lookup_bank | input | 4 | Logical bank number for the lookup port |
| lookup_entry | output | 8 | Entry for `lookup_bank` in the current segment |
| mmr_en | output | 1 | Manager enable flag |
| win_en | output | 1 | Window enable flag |
| boot_ram | output | 1 | Boot-RAM mode flag |
| win_offset | output | 8 | Window offset register |
| clk_reeval | output | 1 | One-cycle clock re-evaluation request |

## Verification
Read data and the lookup result are combinational, so they are due in the same cycle that the address or bank is applied. Every register, flag and the re-evaluation pulse is due one clock edge after the write strobe is sampled. The pulse is due in exactly that cycle and must be low again one cycle later.

The driver places each expectation in the queue in the low phase in which it applies the stimulus. The monitor takes exactly one item per rising edge and compares it one nanosecond after that edge. A write's pulse expectation is therefore compared right after the write edge, and a read is compared while its address is still held.

// File: rtl/mmr_bank_pkg.sv
package mmr_bank_pkg;

    // Bus offsets whose positions the surrounding decoder relies on
    localparam logic [7:0] OFS_TABLE  = 8'h80;
    localparam logic [7:0] OFS_SEGSEL = 8'h90;
    localparam logic [7:0] OFS_WINDOW = 8'h92;
    localparam logic [7:0] OFS_CTRL   = 8'h93;

    // Control register bit positions
    localparam int CTRL_BOOT_BIT = 0;
    localparam int CTRL_WIN_BIT  = 6;
    localparam int CTRL_MMR_BIT  = 7;

    // Constant bits returned on a control read
    localparam logic [7:0] CTRL_FILL = 8'h3E;

    // Value returned for an undecoded read
    localparam logic [7:0] UNMAPPED_READ = 8'hFF;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_TABLE,
        ACC_SEG,
        ACC_WINDOW,
        ACC_CTRL
    } acc_kind_e;

endpackage

// File: rtl/mmr_bank_table.sv
module mmr_bank_table #(
    parameter int DEPTH   = 128,
    parameter int IDX_W   = 7,
    parameter int ENTRY_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx_a,
    output logic [ENTRY_W-1:0] rd_data_a,
    input  logic [IDX_W-1:0]   rd_idx_b,
    output logic [ENTRY_W-1:0] rd_data_b
);

    logic [ENTRY_W-1:0] ent_q [DEPTH];

    // One register per entry, each with its own decoded write enable
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (hit) begin
                ent_q[i] <= wr_data;
            end
        end
    end

    // Bus read port and lookup read port
    assign rd_data_a = ent_q[rd_idx_a];
    assign rd_data_b = ent_q[rd_idx_b];

endmodule

// File: rtl/mmr_bank_ctrl.sv
module mmr_bank_ctrl
    import mmr_bank_pkg::*;
#(
    parameter int SEG_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr,
    input  logic              win_wr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEG_W-1:0]  seg_o,
    output logic [DATA_W-1:0] win_off_o,
    output logic              boot_o,
    output logic              win_en_o,
    output logic              mmr_en_o,
    output logic              reeval_o
);

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [DATA_W-1:0] win;
        logic              boot;
        logic              win_en;
        logic              mmr_en;
        logic              reeval;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.reeval = 1'b0;

        if (seg_wr) begin
            st_d.seg = wdata[SEG_W-1:0];
        end

        if (win_wr) begin
            st_d.win = wdata;
        end

        if (ctrl_wr) begin
            st_d.boot   = wdata[CTRL_BOOT_BIT];
            st_d.win_en = wdata[CTRL_WIN_BIT];
            st_d.mmr_en = wdata[CTRL_MMR_BIT];
            st_d.reeval = wdata[CTRL_MMR_BIT] ^ st_q.mmr_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o     = st_q.seg;
    assign win_off_o = st_q.win;
    assign boot_o    = st_q.boot;
    assign win_en_o  = st_q.win_en;
    assign mmr_en_o  = st_q.mmr_en;
    assign reeval_o  = st_q.reeval;

    // R7: a request is only raised when the enable really moved
    assert_pulse_only_on_change_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        reeval_o |-> (mmr_en_o != $past(mmr_en_o))
    );

    // R7: every change of the enable is accompanied by a request
    assert_change_raises_pulse_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (mmr_en_o != $past(mmr_en_o)) |-> reeval_o
    );

    // R5: the enable follows bit 7 of the control write
    assert_ctrl_load_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (mmr_en_o == $past(wdata[CTRL_MMR_BIT]))
    );

    // R3: the segment holds unless its own offset is written
    assert_seg_hold_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        !seg_wr |=> $stable(seg_o)
    );

    // R4: the window offset holds unless its own offset is written
    assert_win_hold_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        !win_wr |=> $stable(win_off_o)
    );

endmodule

// File: rtl/mmr_bank_regs.sv
module mmr_bank_regs
    import mmr_bank_pkg::*;
#(
    parameter bit EXTENDED      = 1'b0,
    parameter int NUM_SEGS      = 8,
    parameter int BANKS_PER_SEG = 16,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [3:0]        lookup_bank,
    output logic [DATA_W-1:0] lookup_entry,
    output logic              mmr_en,
    output logic              win_en,
    output logic              boot_ram,
    output logic [DATA_W-1:0] win_offset,
    output logic              clk_reeval
);

    localparam int SEG_W      = EXTENDED ? 3 : 2;
    localparam int ENTRY_W    = EXTENDED ? DATA_W : 6;
    localparam int BANK_W     = $clog2(BANKS_PER_SEG);
    localparam int DEPTH      = NUM_SEGS * BANKS_PER_SEG;
    localparam int IDX_W      = $clog2(DEPTH);
    localparam int SEG_SLOT_W = IDX_W - BANK_W;
    localparam logic [DATA_W-1:0] ENTRY_MASK = DATA_W'((1 << ENTRY_W) - 1);

    acc_kind_e           acc_kind;
    logic [SEG_W-1:0]    seg;
    logic [IDX_W-1:0]    bus_idx;
    logic [IDX_W-1:0]    look_idx;
    logic [ENTRY_W-1:0]  tbl_bus_rd;
    logic [ENTRY_W-1:0]  tbl_look_rd;
    logic [DATA_W-1:0]   ctrl_rd;

    // Offset decode
    always_comb begin
        if (bus_addr[ADDR_W-1:BANK_W] == OFS_TABLE[ADDR_W-1:BANK_W]) begin
            acc_kind = ACC_TABLE;
        end else if (bus_addr == OFS_SEGSEL) begin
            acc_kind = ACC_SEG;
        end else if (bus_addr == OFS_WINDOW) begin
            acc_kind = ACC_WINDOW;
        end else if (bus_addr == OFS_CTRL) begin
            acc_kind = ACC_CTRL;
        end else begin
            acc_kind = ACC_NONE;
        end
    end

    // Table index: bank in the low bits, segment above it
    assign bus_idx  = {SEG_SLOT_W'(seg), bus_addr[BANK_W-1:0]};
    assign look_idx = {SEG_SLOT_W'(seg), lookup_bank[BANK_W-1:0]};

    mmr_bank_table #(
        .DEPTH   (DEPTH),
        .IDX_W   (IDX_W),
        .ENTRY_W (ENTRY_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && (acc_kind == ACC_TABLE)),
        .wr_idx    (bus_idx),
        .wr_data   (bus_wdata[ENTRY_W-1:0]),
        .rd_idx_a  (bus_idx),
        .rd_data_a (tbl_bus_rd),
        .rd_idx_b  (look_idx),
        .rd_data_b (tbl_look_rd)
    );

    mmr_bank_ctrl #(
        .SEG_W  (SEG_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_wr    (bus_wr && (acc_kind == ACC_SEG)),
        .win_wr    (bus_wr && (acc_kind == ACC_WINDOW)),
        .ctrl_wr   (bus_wr && (acc_kind == ACC_CTRL)),
        .wdata     (bus_wdata),
        .seg_o     (seg),
        .win_off_o (win_offset),
        .boot_o    (boot_ram),
        .win_en_o  (win_en),
        .mmr_en_o  (mmr_en),
        .reeval_o  (clk_reeval)
    );

    // Control read-back
    always_comb begin
        ctrl_rd                = CTRL_FILL;
        ctrl_rd[CTRL_BOOT_BIT] = boot_ram;
        ctrl_rd[CTRL_WIN_BIT]  = win_en;
        ctrl_rd[CTRL_MMR_BIT]  = mmr_en;
    end

    // Read mux
    always_comb begin
        unique case (acc_kind)
            ACC_TABLE:  bus_rdata = DATA_W'(tbl_bus_rd);
            ACC_WINDOW: bus_rdata = win_offset;
            ACC_CTRL:   bus_rdata = ctrl_rd;
            default:    bus_rdata = UNMAPPED_READ;
        endcase
    end

    assign lookup_entry = DATA_W'(tbl_look_rd);

    // R2, R8: a table write is returned masked on the lookup port
    assert_table_readback_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_wr) && ($past(acc_kind) == ACC_TABLE)
            && (lookup_bank == $past(bus_addr[3:0])) && $stable(seg))
        |-> (lookup_entry == ($past(bus_wdata) & ENTRY_MASK))
    );

    // R6: the constant bits of a control read are always ones
    assert_ctrl_fill_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_CTRL) |-> (bus_rdata[5:1] == 5'b11111)
    );

    // R2: no entry carries bits above the configured width
    assert_entry_width_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (lookup_entry & ~ENTRY_MASK) == '0
    );

endmodule

// File: tb/mmr_bank_regs_test.sv
module mmr_bank_regs_test;

    localparam int SEL_RDATA  = 0;
    localparam int SEL_LOOKUP = 1;
    localparam int SEL_PULSE  = 2;
    localparam int SEL_FLAGS  = 3;
    localparam int SEL_WINOFF = 4;

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] lookup_bank = 4'h0;
    logic [7:0] lookup_entry;
    logic       mmr_en, win_en, boot_ram, clk_reeval;
    logic [7:0] win_offset;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    always #2.5 clk = ~clk;

    mmr_bank_regs uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .lookup_bank  (lookup_bank),
        .lookup_entry (lookup_entry),
        .mmr_en       (mmr_en),
        .win_en       (win_en),
        .boot_ram     (boot_ram),
        .win_offset   (win_offset),
        .clk_reeval   (clk_reeval)
    );

    // Monitor: one expectation per rising edge, compared just after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t      it;
                logic [7:0] obs;
                it = q.pop_front();
                case (it.sel)
                    SEL_RDATA:  obs = bus_rdata;
                    SEL_LOOKUP: obs = lookup_entry;
                    SEL_PULSE:  obs = {7'b0, clk_reeval};
                    SEL_FLAGS:  obs = {5'b0, mmr_en, win_en, boot_ram};
                    default:    obs = win_offset;
                endcase
                n_chk++;
                if (obs !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, obs, it.exp);
                end
            end
        end
    end

    // Write; the pulse expectation applies to the write edge itself
    task automatic do_wr(input logic [7:0] a, input logic [7:0] d, input logic exp_pulse);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        q.push_back('{SEL_PULSE, {7'b0, exp_pulse}, "R7 reeval pulse at write edge"});
    endtask

    task automatic expect_out(input int sel, input logic [7:0] a, input logic [7:0] exp,
                              input string tag);
        @(negedge clk);
        bus_wr = 1'b0;
        if (sel == SEL_LOOKUP) lookup_bank = a[3:0];
        else                   bus_addr    = a;
        q.push_back('{sel, exp, tag});
    endtask

    task automatic do_reset();
        @(negedge clk);
        bus_wr = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        expect_out(SEL_RDATA, 8'h80, 8'h00, "R1 table entry after reset");
        expect_out(SEL_RDATA, 8'h8F, 8'h00, "R1 last entry after reset");
        expect_out(SEL_FLAGS, 8'h00, 8'h00, "R1 flags after reset");
        expect_out(SEL_WINOFF, 8'h00, 8'h00, "R1 window offset after reset");
        expect_out(SEL_PULSE, 8'h00, 8'h00, "R1 pulse after reset");
        expect_out(SEL_RDATA, 8'h93, 8'h3E, "R1 R6 control read after reset");

        // R2 table write/read, width clipping; R10 next-cycle visibility
        do_wr(8'h85, 8'hFF, 1'b0);
        expect_out(SEL_RDATA, 8'h85, 8'h3F, "R2 R10 entry clipped to 6 bits");
        do_wr(8'h8F, 8'h2A, 1'b0);
        expect_out(SEL_RDATA, 8'h8F, 8'h2A, "R2 entry F readback");
        expect_out(SEL_RDATA, 8'h84, 8'h00, "R2 neighbour entry untouched");

        // R3 segment selection
        do_wr(8'h90, 8'hFD, 1'b0);
        expect_out(SEL_RDATA, 8'h85, 8'h00, "R3 segment 1 starts empty");
        do_wr(8'h85, 8'h11, 1'b0);
        expect_out(SEL_RDATA, 8'h85, 8'h11, "R3 segment 1 entry 5");
        expect_out(SEL_LOOKUP, 8'h05, 8'h11, "R8 lookup bank 5 in segment 1");
        expect_out(SEL_LOOKUP, 8'h0F, 8'h00, "R8 lookup bank F in segment 1");
        do_wr(8'h90, 8'h00, 1'b0);
        expect_out(SEL_RDATA, 8'h85, 8'h3F, "R3 segment 0 entry 5 kept");
        expect_out(SEL_LOOKUP, 8'h0F, 8'h2A, "R8 lookup bank F in segment 0");
        do_wr(8'h90, 8'h07, 1'b0);
        expect_out(SEL_RDATA, 8'h85, 8'h00, "R3 segment 3 entry 5");
        do_wr(8'h90, 8'h05, 1'b0);
        expect_out(SEL_RDATA, 8'h85, 8'h11, "R3 bit 2 ignored selects segment 1");
        do_wr(8'h90, 8'h00, 1'b0);

        // R4 window offset
        do_wr(8'h92, 8'hA5, 1'b0);
        expect_out(SEL_WINOFF, 8'h00, 8'hA5, "R4 window offset output");
        expect_out(SEL_RDATA, 8'h92, 8'hA5, "R4 window offset readback");

        // R5 R6 R7 control register
        do_wr(8'h93, 8'hC1, 1'b1);
        expect_out(SEL_PULSE, 8'h00, 8'h00, "R7 pulse lasts one cycle");
        expect_out(SEL_FLAGS, 8'h00, 8'h07, "R5 all three flags set");
        expect_out(SEL_RDATA, 8'h93, 8'hFF, "R6 control read all set");
        do_wr(8'h93, 8'h81, 1'b0);
        expect_out(SEL_FLAGS, 8'h00, 8'h05, "R5 window enable cleared");
        expect_out(SEL_RDATA, 8'h93, 8'hBF, "R6 control read 0x81");
        do_wr(8'h93, 8'h40, 1'b1);
        expect_out(SEL_FLAGS, 8'h00, 8'h02, "R5 only window enable");
        expect_out(SEL_RDATA, 8'h93, 8'h7E, "R6 control read 0x40");
        do_wr(8'h93, 8'h3E, 1'b0);
        expect_out(SEL_FLAGS, 8'h00, 8'h00, "R5 bits 5..1 have no effect");

        // R9 unmapped offsets
        expect_out(SEL_RDATA, 8'h90, 8'hFF, "R9 segment offset reads FF");
        expect_out(SEL_RDATA, 8'h91, 8'hFF, "R9 offset 91 reads FF");
        expect_out(SEL_RDATA, 8'h7F, 8'hFF, "R9 offset 7F reads FF");
        expect_out(SEL_RDATA, 8'h94, 8'hFF, "R9 offset 94 reads FF");
        do_wr(8'h05, 8'h00, 1'b0);
        expect_out(SEL_RDATA, 8'h85, 8'h3F, "R9 write to 05 leaves entry 5");
        do_wr(8'h02, 8'h00, 1'b0);
        expect_out(SEL_WINOFF, 8'h00, 8'hA5, "R9 write to 02 leaves window");
        do_wr(8'h03, 8'hFF, 1'b0);
        expect_out(SEL_FLAGS, 8'h00, 8'h00, "R9 write to 03 leaves flags");
        do_wr(8'h10, 8'h01, 1'b0);
        expect_out(SEL_RDATA, 8'h85, 8'h3F, "R9 write to 10 leaves segment");

        // R1 reset in mid-run
        do_wr(8'h93, 8'hC1, 1'b1);
        do_reset();
        expect_out(SEL_FLAGS, 8'h00, 8'h00, "R1 flags cleared by reset");
        expect_out(SEL_RDATA, 8'h85, 8'h00, "R1 entries cleared by reset");
        expect_out(SEL_WINOFF, 8'h00, 8'h00, "R1 window cleared by reset");
        expect_out(SEL_PULSE, 8'h00, 8'h00, "R1 R7 no pulse from reset");

        @(negedge clk);
        repeat (3) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule